// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and a calendar: seconds, minutes, hours, day of week, date, month and a two-digit year. Every field is held and presented in packed BCD. A prescaler counts pulses of a 32.768 kHz clock enable and produces a one-second advance. Each advance ripples carries through the fields in a single clock cycle. Month lengths are corrected automatically, and February gets a 29th day in every year divisible by four.

The hours field can count in 24-hour form or in 12-hour form with an AM/PM flag. Software loads any field through a simple write port. A control byte holds an oscillator-stop bit and a write-protect bit. Writing the seconds field clears the prescaler, so the next second begins at the moment of the write. A one-cycle strobe marks each cycle in which newly advanced values appear; an alarm comparator can use it.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the outputs read 00:00:00 in 24-hour form, day of week 1, date 01, month 01, year 00, and the update strobe is low.
- R2: The seconds advance by one on the PRESCALE-th counted pulse of `tick_en` after the prescaler was last cleared. `o_upd` is high for exactly the one cycle in which the advanced values first appear.
- R3: Seconds and minutes count in BCD from 00 to 59 (for example 09 is followed by 10). On leaving 59 the field returns to 00 and carries into the next field.
- R4: With hours bit 6 = 0 (24-hour form), the hours count in BCD from 00 to 23, with bit 5 holding the tens digit 2. Leaving 23 gives 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour form), bits 4:0 hold a BCD hour from 01 to 12 and bit 5 = 1 means PM. The order is 11 AM, 12 PM, 01 PM … 11 PM, 12 AM, 01 AM. The PM flag flips on the 11-to-12 step, and the step from 11 PM to 12 AM advances the day.
- R6: The day of week advances when the day advances, counting 1 to 7 and then back to 1.
- R7: Dates run to 31, or to 30 in months 04, 06, 09 and 11. February runs to 29 when the BCD year is divisible by 4 (00 included), and to 28 otherwise. Past the last date the date becomes 01 and the month advances; month 12 goes to 01 and advances the year; year 99 goes to 00.
- R8: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 control. An accepted write to address 0 clears the prescaler and cancels any advance in that cycle. A write to any other field takes its written value, while the remaining fields still advance if a second elapses in that cycle.
- R9: Control bit 7 = 1 stops the prescaler and all counting; no advance and no strobe occur while it is set. Counting resumes when it is cleared.
- R10: While control bit 6 (write protect) is 1, writes to all fields and to control bit 7 are ignored. Only control bit 6 itself stays writable.
- R11: Bits with no meaning are dropped on write and read as 0. Seconds and minutes keep bits 6:0, hours keep 6:0, day of week keeps 2:0, date keeps 5:0, month keeps 4:0, and year keeps all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 seconds … 7 control) |
| wr_data | input | 8 | Write data |
| o_sec | output | 8 | Seconds, BCD |
| o_min | output | 8 | Minutes, BCD |
| o_hour | output | 8 | Hours with mode and AM/PM bits |
| o_dow | output | 8 | Day of week 1..7 |
| o_date | output | 8 | Date, BCD |
| o_month | output | 8 | Month, BCD |
| o_year | output | 8 | Year 00..99, BCD |
| o_upd | output | 1 | One-cycle strobe on each advance |

## Verification
The assertions on digit ranges and 12-hour values assume that software only ever writes legal BCD values in range for each field, and that PRESCALE is at least 2. The bench keeps to this: every value it loads is a legal time or date. The bits it sets deliberately for the masking check fall only in positions that are dropped. The write-protect assertion only looks at cycles in which counting is also stopped, so that a carry cannot be mistaken for a leaked write. The bench therefore drives protected writes both with counting stopped and with counting running.

// File: rtl/tk_pkg.sv
package tk_pkg;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DOW   = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_YEAR  = 3'd6,
        A_CTRL  = 3'd7
    } tk_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } tk_time_t;

    typedef struct packed {
        tk_time_t tm;
        logic     stop;
        logic     wp;
        logic     upd;
    } tk_state_t;

    // Two-digit BCD increment; 99 wraps to 00
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = (v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // BCD year divisible by four
    function automatic logic is_leap(input logic [7:0] y);
        logic [3:0] u;
        u = y[3:0];
        if (y[4] == 1'b0)
            return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        else
            return (u == 4'd2) || (u == 4'd6);
    endfunction

    function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic clr,
    output logic sec_pulse
);
    localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_pulse = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (run && tick_en) begin
            if (cnt_q == LAST) begin
                cnt_d     = '0;
                sec_pulse = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tk_hour_step.sv
module tk_hour_step (
    input  logic [6:0] hour,
    output logic [6:0] hour_nx,
    output logic       day_carry
);
    logic [7:0] inc_v;

    always_comb begin
        hour_nx   = hour;
        day_carry = 1'b0;
        inc_v     = 8'h00;
        if (hour[6] == 1'b0) begin
            // 24-hour form
            if (hour[5:0] == 6'h23) begin
                hour_nx   = 7'h00;
                day_carry = 1'b1;
            end else begin
                inc_v   = tk_pkg::bcd_inc({2'b00, hour[5:0]});
                hour_nx = {1'b0, inc_v[5:0]};
            end
        end else begin
            // 12-hour form: bit 5 PM, bits 4:0 hour 01..12
            if (hour[4:0] == 5'h11) begin
                hour_nx   = {1'b1, ~hour[5], 5'h12};
                day_carry = hour[5];
            end else if (hour[4:0] == 5'h12) begin
                hour_nx = {1'b1, hour[5], 5'h01};
            end else begin
                inc_v   = tk_pkg::bcd_inc({3'b000, hour[4:0]});
                hour_nx = {1'b1, hour[5], inc_v[4:0]};
            end
        end
    end

endmodule

// File: rtl/tk_date_step.sv
module tk_date_step (
    input  logic [5:0] date,
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] date_nx,
    output logic [4:0] month_nx,
    output logic [7:0] year_nx
);
    logic [7:0] inc_d, inc_m;

    always_comb begin
        inc_d    = tk_pkg::bcd_inc({2'b00, date});
        inc_m    = tk_pkg::bcd_inc({3'b000, month});
        date_nx  = inc_d[5:0];
        month_nx = month;
        year_nx  = year;
        if (date == tk_pkg::last_date(month, year)) begin
            date_nx = 6'h01;
            if (month == 5'h12) begin
                month_nx = 5'h01;
                year_nx  = tk_pkg::bcd_inc(year);
            end else begin
                month_nx = inc_m[4:0];
            end
        end
    end

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] o_sec,
    output logic [7:0] o_min,
    output logic [7:0] o_hour,
    output logic [7:0] o_dow,
    output logic [7:0] o_date,
    output logic [7:0] o_month,
    output logic [7:0] o_year,
    output logic       o_upd
);
    import tk_pkg::*;

    tk_state_t  st_d, st_q;
    logic       wr_ok, sec_wr, sec_pulse, day_carry;
    logic [6:0] hour_nx;
    logic [5:0] date_nx;
    logic [4:0] month_nx;
    logic [7:0] year_nx, inc_s, inc_mi, inc_w;

    assign wr_ok  = wr_en && !st_q.wp;
    assign sec_wr = wr_ok && (wr_addr == A_SEC);

    tk_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (!st_q.stop),
        .clr       (sec_wr),
        .sec_pulse (sec_pulse)
    );

    tk_hour_step u_hour (
        .hour      (st_q.tm.hour),
        .hour_nx   (hour_nx),
        .day_carry (day_carry)
    );

    tk_date_step u_date (
        .date     (st_q.tm.date),
        .month    (st_q.tm.month),
        .year     (st_q.tm.year),
        .date_nx  (date_nx),
        .month_nx (month_nx),
        .year_nx  (year_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        inc_s    = bcd_inc({1'b0, st_q.tm.sec});
        inc_mi   = bcd_inc({1'b0, st_q.tm.min});
        inc_w    = 8'h00;

        // one-second advance with carry ripple
        if (sec_pulse) begin
            st_d.upd = 1'b1;
            if (st_q.tm.sec == 7'h59) begin
                st_d.tm.sec = 7'h00;
                if (st_q.tm.min == 7'h59) begin
                    st_d.tm.min  = 7'h00;
                    st_d.tm.hour = hour_nx;
                    if (day_carry) begin
                        inc_w         = {5'b0, st_q.tm.dow} + 8'd1;
                        st_d.tm.dow   = (st_q.tm.dow == 3'd7) ? 3'd1 : inc_w[2:0];
                        st_d.tm.date  = date_nx;
                        st_d.tm.month = month_nx;
                        st_d.tm.year  = year_nx;
                    end
                end else begin
                    st_d.tm.min = inc_mi[6:0];
                end
            end else begin
                st_d.tm.sec = inc_s[6:0];
            end
        end

        // software writes win over the advance for the written field
        if (wr_ok) begin
            case (wr_addr)
                A_SEC:   st_d.tm.sec   = wr_data[6:0];
                A_MIN:   st_d.tm.min   = wr_data[6:0];
                A_HOUR:  st_d.tm.hour  = wr_data[6:0];
                A_DOW:   st_d.tm.dow   = wr_data[2:0];
                A_DATE:  st_d.tm.date  = wr_data[5:0];
                A_MONTH: st_d.tm.month = wr_data[4:0];
                A_YEAR:  st_d.tm.year  = wr_data;
                default: st_d.stop     = wr_data[7];
            endcase
        end
        if (wr_en && (wr_addr == A_CTRL))
            st_d.wp = wr_data[6];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tm.dow   <= 3'd1;
            st_q.tm.date  <= 6'h01;
            st_q.tm.month <= 5'h01;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_sec   = {1'b0, st_q.tm.sec};
    assign o_min   = {1'b0, st_q.tm.min};
    assign o_hour  = {1'b0, st_q.tm.hour};
    assign o_dow   = {5'b0, st_q.tm.dow};
    assign o_date  = {2'b0, st_q.tm.date};
    assign o_month = {3'b0, st_q.tm.month};
    assign o_year  = st_q.tm.year;
    assign o_upd   = st_q.upd;

    assert_sec_digits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tm.sec[3:0] <= 4'd9) && (st_q.tm.sec[6:4] <= 3'd5));

    assert_hour12_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tm.hour[6] |-> ((st_q.tm.hour[4:0] != 5'h00) && (st_q.tm.hour[4:0] <= 5'h12)));

    assert_upd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> !st_q.upd);

    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !wr_en) |=> ($stable(st_q.tm) && !st_q.upd));

    assert_wp_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wp && st_q.stop && wr_en) |=> ($stable(st_q.tm) && st_q.stop));

    assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tm.dow != 3'd0));

endmodule

// File: tb/tb_bcd_timekeeper.sv
module tb_bcd_timekeeper;
    localparam int PS = 4;
    localparam int NV = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] o_sec, o_min, o_hour, o_dow, o_date, o_month, o_year;
    logic       o_upd;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcd_timekeeper #(.PRESCALE(PS)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .o_sec(o_sec), .o_min(o_min), .o_hour(o_hour), .o_dow(o_dow),
        .o_date(o_date), .o_month(o_month), .o_year(o_year), .o_upd(o_upd)
    );

    // {hour,min,sec,dow,date,month,year} loaded, then expected one second later
    localparam logic [111:0] VEC [NV] = '{
        {56'h12_34_56_03_15_06_23, 56'h12_34_57_03_15_06_23},  // R2
        {56'h10_59_59_04_15_06_23, 56'h11_00_00_04_15_06_23},  // R3
        {56'h23_59_59_07_28_02_24, 56'h00_00_00_01_29_02_24},  // R4 R6 R7
        {56'h23_59_59_02_28_02_23, 56'h00_00_00_03_01_03_23},  // R7
        {56'h23_59_59_05_29_02_00, 56'h00_00_00_06_01_03_00},  // R7
        {56'h23_59_59_01_30_04_25, 56'h00_00_00_02_01_05_25},  // R7
        {56'h23_59_59_03_31_01_25, 56'h00_00_00_04_01_02_25},  // R7
        {56'h23_59_59_06_31_12_99, 56'h00_00_00_07_01_01_00},  // R7
        {56'h23_59_59_04_30_07_25, 56'h00_00_00_05_31_07_25},  // R7
        {56'h23_59_59_02_28_02_12, 56'h00_00_00_03_29_02_12},  // R7
        {56'h23_59_59_02_28_02_18, 56'h00_00_00_03_01_03_18},  // R7
        {56'h51_59_59_02_10_03_25, 56'h72_00_00_02_10_03_25},  // R5
        {56'h71_59_59_02_10_03_25, 56'h52_00_00_03_11_03_25},  // R5
        {56'h72_59_59_02_10_03_25, 56'h61_00_00_02_10_03_25},  // R5
        {56'h52_59_59_02_10_03_25, 56'h41_00_00_02_10_03_25},  // R5
        {56'h09_59_59_02_30_11_25, 56'h10_00_00_02_30_11_25},  // R4
        {56'h19_59_59_02_30_11_25, 56'h20_00_00_02_30_11_25}   // R4
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    function automatic logic [63:0] now();
        return {8'h00, o_hour, o_min, o_sec, o_dow, o_date, o_month, o_year};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", {now(), 7'd0, o_upd}, {64'h00_00_00_00_01_01_01_00, 8'h00});

        // R11 masking of meaningless bits
        wr(3'd2, 8'h92);
        wr(3'd3, 8'hF1);
        wr(3'd4, 8'hC5);
        chk("R11 masked writes", {40'd0, o_hour, o_dow, o_date}, {40'd0, 24'h12_01_05});

        // vector table
        for (int v = 0; v < NV; v++) begin
            wr(3'd6, VEC[v][63:56]);
            wr(3'd5, VEC[v][71:64]);
            wr(3'd4, VEC[v][79:72]);
            wr(3'd3, VEC[v][87:80]);
            wr(3'd2, VEC[v][111:104]);
            wr(3'd1, VEC[v][103:96]);
            wr(3'd0, VEC[v][95:88]);
            ticks(PS);
            chk($sformatf("R2-vector %0d (R3 R4 R5 R6 R7)", v), now(), {8'h00, VEC[v][55:0]});
        end

        // R8 seconds write clears prescaler
        wr(3'd0, 8'h10);
        ticks(2);
        wr(3'd0, 8'h20);
        ticks(PS - 1);
        chk("R8 no advance after clear", {56'd0, o_sec}, 64'h20);
        ticks(1);
        chk("R8 advance after full count", {56'd0, o_sec}, 64'h21);

        // R8 other field write while a second elapses
        ticks(PS - 1);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h45;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        chk("R8 concurrent write and count", {48'd0, o_min, o_sec}, 64'h45_22);

        // R2 strobe timing
        wr(3'd0, 8'h00);
        ticks(PS - 1);
        chk("R2 strobe low before second", {63'd0, o_upd}, 64'd0);
        ticks(1);
        chk("R2 strobe high with new value", {55'd0, o_upd, o_sec}, {55'd0, 1'b1, 8'h01});
        @(negedge clk);
        chk("R2 strobe one cycle", {63'd0, o_upd}, 64'd0);

        // R9 oscillator stop
        wr(3'd0, 8'h30);
        wr(3'd7, 8'h80);
        ticks(2 * PS);
        chk("R9 stopped seconds", {55'd0, o_upd, o_sec}, {55'd0, 1'b0, 8'h30});
        wr(3'd7, 8'h00);
        wr(3'd0, 8'h40);
        ticks(PS);
        chk("R9 resumes after clear", {56'd0, o_sec}, 64'h41);

        // R10 write protect
        wr(3'd0, 8'h50);
        wr(3'd7, 8'h40);
        wr(3'd1, 8'h33);
        wr(3'd0, 8'h11);
        wr(3'd7, 8'hC0);
        chk("R10 field writes blocked", {48'd0, o_min, o_sec}, {48'd0, 8'h45, 8'h50});
        ticks(PS);
        chk("R10 stop bit blocked, still counting", {56'd0, o_sec}, 64'h51);
        wr(3'd7, 8'h00);
        wr(3'd0, 8'h07);
        chk("R10 protect bit itself writable", {56'd0, o_sec}, 64'h07);

        // R10 protected writes with counting stopped
        wr(3'd7, 8'h80);
        wr(3'd7, 8'hC0);
        wr(3'd2, 8'h05);
        wr(3'd7, 8'h40);
        ticks(PS);
        chk("R10 stop held under protect", {48'd0, o_hour, o_sec}, {48'd0, o_hour == 8'h05 ? 8'hFF : o_hour, 8'h07});
        wr(3'd7, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule